// File: doc/BRIEF.md
# Priority Memory Select Resolver

This block turns a 16-bit processor address into a single chip select for one of several on-chip memory and I/O targets. Software programs ten address windows, each with an inclusive lower and upper bound and an enable bit. Four windows belong to the primary flash sectors and two to the secondary flash sectors. Two windows are OR-ed together into the SRAM select. One window drives the I/O select, and one drives the peripheral I/O select.

Windows on different priority levels may overlap. In that case a fixed ranking decides which target gets the address. SRAM, I/O and peripheral I/O rank highest, secondary flash ranks next and primary flash ranks lowest. Windows on the same level must stay apart. A registered set of error flags reports same-level overlaps and flash windows that are wider than their physical sector. The flags are refreshed one cycle after each configuration write.

A separate output shows when the SRAM is running from its backup battery. It is formed from an external supply-below-battery comparator input and a standby-enable input.

Top module: `memsel_resolver`

## Requirements
- R1: Configuration writes happen on a clock edge with `cfg_we` high. `cfg_addr[5:2]` selects the window: 0–3 primary sectors, 4–5 secondary sectors, 6–7 the two SRAM terms, 8 I/O, 9 peripheral I/O. `cfg_addr[1:0]` selects the field: 0 lower bound, 1 upper bound, 2 enable (data bit 0). Field 3 and window indexes above 9 are ignored. After reset every window is disabled with both bounds at 0, `none_sel_o` is high and every error flag is low.
- R2: A window matches an address when it is enabled, its lower bound is not above its upper bound, and lower ≤ address ≤ upper (both bounds inclusive). Selects follow `addr` combinationally, in the same cycle. When nothing matches, `none_sel_o` is high.
- R3: A matching SRAM, I/O or peripheral I/O window beats any secondary or primary match. A secondary match beats any primary match.
- R4: Exactly one of `pri_sel_o`, `sec_sel_o`, `sram_sel_o`, `io_sel_o`, `pio_sel_o`, `none_sel_o` is asserted, and it is a single bit. In an illegal same-level overlap, the lowest window index wins. Within the top level, SRAM wins over I/O, and I/O wins over peripheral I/O.
- R5: `sram_sel_o` is high when either of the two SRAM windows matches.
- R6: Take primary sector 0 at 8000h–BFFFh, secondary sector 0 at 8000h–9FFFh and SRAM term 0 at 8000h–87FFh. Then 8000h–87FFh selects SRAM, 8800h–9FFFh selects secondary 0, A000h–BFFFh selects primary 0, and 7FFFh and C000h select nothing.
- R7: `err_pri_ovl_o` goes high when two valid primary windows share any address.
- R8: `err_sec_ovl_o` goes high when the two valid secondary windows share any address.
- R9: `err_top_ovl_o` goes high when windows of different top-level targets (SRAM, I/O, peripheral I/O) share any address. Overlap between the two SRAM terms is not an error.
- R10: `err_size_o` goes high when a valid primary window spans more than `PRI_SPAN` (16384) addresses, or a valid secondary window spans more than `SEC_SPAN` (8192).
- R11: If a write lands on clock edge k, the error flags reflect the new configuration from edge k+1. They hold their value while no write occurs.
- R12: `batt_on_o` is high exactly when `vcc_below_bat` and `stby_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Window index and field of the write |
| cfg_wdata | input | 16 | Write data |
| addr | input | 16 | Processor address to decode |
| vcc_below_bat | input | 1 | Comparator: supply below battery voltage |
| stby_en | input | 1 | Battery backup connected and enabled |
| pri_sel_o | output | 4 | Primary flash sector selects |
| sec_sel_o | output | 2 | Secondary flash sector selects |
| sram_sel_o | output | 1 | SRAM select |
| io_sel_o | output | 1 | I/O select |
| pio_sel_o | output | 1 | Peripheral I/O select |
| none_sel_o | output | 1 | No window matched |
| err_pri_ovl_o | output | 1 | Primary windows overlap |
| err_sec_ovl_o | output | 1 | Secondary windows overlap |
| err_top_ovl_o | output | 1 | Top-level targets overlap |
| err_size_o | output | 1 | Flash window wider than its sector |
| batt_on_o | output | 1 | SRAM powered from battery |

## Verification
The bench builds the block with its default parameters: four primary and two secondary sectors, two SRAM terms, a 16-bit address, and sector spans of 16384 and 8192. With these values the three-range example fits as given. The sector limits can be crossed by one address, so the size check is tested exactly at its boundary. Random windows over the full 16-bit space often produce overlaps both within and across levels. This exercises the lowest-index tie rule and every error flag against the bench's own behavioural model.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

  typedef enum logic [1:0] {
    FLD_LO   = 2'd0,
    FLD_HI   = 2'd1,
    FLD_EN   = 2'd2,
    FLD_RSVD = 2'd3
  } fld_e;

  function automatic logic spans_meet(
    input logic [15:0] a_lo, input logic [15:0] a_hi,
    input logic [15:0] b_lo, input logic [15:0] b_hi);
    return (a_lo <= b_hi) && (b_lo <= a_hi);
  endfunction

endpackage

// File: rtl/memsel_window.sv
module memsel_window
  import memsel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int MY_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W+1:0]  cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o,
  output logic              valid_o,
  output logic              hit_o
);

  logic              wr_sel;
  logic [ADDR_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              en_q, en_d;

  assign wr_sel = cfg_we && (cfg_addr[IDX_W+1:2] == IDX_W'(MY_IDX));

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    en_d = en_q;
    if (wr_sel) begin
      case (fld_e'(cfg_addr[1:0]))
        FLD_LO:  lo_d = cfg_wdata;
        FLD_HI:  hi_d = cfg_wdata;
        FLD_EN:  en_d = cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      en_q <= 1'b0;
    end else if (wr_sel) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      en_q <= en_d;
    end
  end

  assign lo_o    = lo_q;
  assign hi_o    = hi_q;
  assign valid_o = en_q && (lo_q <= hi_q);
  assign hit_o   = valid_o && (addr >= lo_q) && (addr <= hi_q);

  // R1
  lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && cfg_addr[1:0] == 2'd0) |=> (lo_o == $past(cfg_wdata)));

  // R1
  hi_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && cfg_addr[1:0] == 2'd1) |=> (hi_o == $past(cfg_wdata)));

endmodule

// File: rtl/memsel_cfg_check.sv
module memsel_cfg_check
  import memsel_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int N_PRI    = 4,
  parameter int N_SEC    = 2,
  parameter int N_SRAM   = 2,
  parameter int PRI_SPAN = 16384,
  parameter int SEC_SPAN = 8192,
  localparam int SEC0    = N_PRI,
  localparam int TOP0    = N_PRI + N_SEC,
  localparam int IO_IDX  = TOP0 + N_SRAM,
  localparam int N_WIN   = IO_IDX + 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [N_WIN-1:0][ADDR_W-1:0] lo_i,
  input  logic [N_WIN-1:0][ADDR_W-1:0] hi_i,
  input  logic [N_WIN-1:0]             valid_i,
  output logic                         err_pri_o,
  output logic                         err_sec_o,
  output logic                         err_top_o,
  output logic                         err_size_o
);

  logic       dirty_q, dirty_d;
  logic [3:0] err_q, err_d;
  logic       pri_ov, sec_ov, top_ov, size_bad;

  function automatic int top_group(input int idx);
    return (idx < IO_IDX) ? 0 : (idx - IO_IDX + 1);
  endfunction

  always_comb begin
    logic [ADDR_W:0] span;
    pri_ov   = 1'b0;
    sec_ov   = 1'b0;
    top_ov   = 1'b0;
    size_bad = 1'b0;
    span     = '0;
    for (int i = 0; i < N_WIN; i++) begin
      for (int j = i + 1; j < N_WIN; j++) begin
        if (valid_i[i] && valid_i[j] && spans_meet(lo_i[i], hi_i[i], lo_i[j], hi_i[j])) begin
          if (j < SEC0) pri_ov = 1'b1;
          else if (i >= SEC0 && j < TOP0) sec_ov = 1'b1;
          else if (i >= TOP0 && top_group(i) != top_group(j)) top_ov = 1'b1;
        end
      end
      if (i < TOP0 && valid_i[i]) begin
        span = {1'b0, hi_i[i]} - {1'b0, lo_i[i]} + 1'b1;
        if (i < SEC0) begin
          if (span > (ADDR_W+1)'(PRI_SPAN)) size_bad = 1'b1;
        end else begin
          if (span > (ADDR_W+1)'(SEC_SPAN)) size_bad = 1'b1;
        end
      end
    end
  end

  always_comb begin
    dirty_d = cfg_we;
    err_d   = {pri_ov, sec_ov, top_ov, size_bad};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty_q <= 1'b0;
    else        dirty_q <= dirty_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= '0;
    else if (dirty_q) err_q <= err_d;
  end

  assign {err_pri_o, err_sec_o, err_top_o, err_size_o} = err_q;

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dirty_q |=> $stable(err_q));

  // R11
  err_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q && !cfg_we) |=> (err_q == $past(err_d)));

endmodule

// File: rtl/memsel_arbiter.sv
module memsel_arbiter #(
  parameter int N_PRI  = 4,
  parameter int N_SEC  = 2,
  parameter int N_SRAM = 2,
  localparam int SEC0   = N_PRI,
  localparam int TOP0   = N_PRI + N_SEC,
  localparam int IO_IDX = TOP0 + N_SRAM,
  localparam int N_WIN  = IO_IDX + 2
) (
  input  logic [N_WIN-1:0] hit_i,
  output logic [N_PRI-1:0] pri_sel_o,
  output logic [N_SEC-1:0] sec_sel_o,
  output logic             sram_sel_o,
  output logic             io_sel_o,
  output logic             pio_sel_o,
  output logic             none_sel_o
);

  logic             top_any, sec_any, pri_any, sram_hit;
  logic [N_PRI-1:0] pri_first;
  logic [N_SEC-1:0] sec_first;

  assign sram_hit = |hit_i[IO_IDX-1:TOP0];
  assign top_any  = |hit_i[N_WIN-1:TOP0];
  assign sec_any  = |hit_i[TOP0-1:SEC0];
  assign pri_any  = |hit_i[SEC0-1:0];

  always_comb begin
    logic found;
    pri_first = '0;
    found     = 1'b0;
    for (int i = 0; i < N_PRI; i++) begin
      if (!found && hit_i[i]) begin
        pri_first[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    sec_first = '0;
    found     = 1'b0;
    for (int i = 0; i < N_SEC; i++) begin
      if (!found && hit_i[SEC0+i]) begin
        sec_first[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  assign sram_sel_o = sram_hit;
  assign io_sel_o   = hit_i[IO_IDX] && !sram_hit;
  assign pio_sel_o  = hit_i[IO_IDX+1] && !sram_hit && !hit_i[IO_IDX];
  assign sec_sel_o  = top_any ? '0 : sec_first;
  assign pri_sel_o  = (top_any || sec_any) ? '0 : pri_first;
  assign none_sel_o = !(top_any || sec_any || pri_any);

endmodule

// File: rtl/memsel_resolver.sv
module memsel_resolver #(
  parameter int ADDR_W   = 16,
  parameter int N_PRI    = 4,
  parameter int N_SEC    = 2,
  parameter int N_SRAM   = 2,
  parameter int PRI_SPAN = 16384,
  parameter int SEC_SPAN = 8192,
  localparam int N_WIN   = N_PRI + N_SEC + N_SRAM + 2,
  localparam int IDX_W   = $clog2(N_WIN),
  localparam int SEC0    = N_PRI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W+1:0]  cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vcc_below_bat,
  input  logic              stby_en,
  output logic [N_PRI-1:0]  pri_sel_o,
  output logic [N_SEC-1:0]  sec_sel_o,
  output logic              sram_sel_o,
  output logic              io_sel_o,
  output logic              pio_sel_o,
  output logic              none_sel_o,
  output logic              err_pri_ovl_o,
  output logic              err_sec_ovl_o,
  output logic              err_top_ovl_o,
  output logic              err_size_o,
  output logic              batt_on_o
);

  logic [1:0]                   rst_pipe_q;
  logic                         rst_n_s;
  logic [N_WIN-1:0][ADDR_W-1:0] lo_w, hi_w;
  logic [N_WIN-1:0]             valid_w, hit_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    memsel_window #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .MY_IDX (g)
    ) u_win (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .addr      (addr),
      .lo_o      (lo_w[g]),
      .hi_o      (hi_w[g]),
      .valid_o   (valid_w[g]),
      .hit_o     (hit_w[g])
    );
  end

  memsel_arbiter #(
    .N_PRI  (N_PRI),
    .N_SEC  (N_SEC),
    .N_SRAM (N_SRAM)
  ) u_arb (
    .hit_i      (hit_w),
    .pri_sel_o  (pri_sel_o),
    .sec_sel_o  (sec_sel_o),
    .sram_sel_o (sram_sel_o),
    .io_sel_o   (io_sel_o),
    .pio_sel_o  (pio_sel_o),
    .none_sel_o (none_sel_o)
  );

  memsel_cfg_check #(
    .ADDR_W   (ADDR_W),
    .N_PRI    (N_PRI),
    .N_SEC    (N_SEC),
    .N_SRAM   (N_SRAM),
    .PRI_SPAN (PRI_SPAN),
    .SEC_SPAN (SEC_SPAN)
  ) u_chk (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cfg_we     (cfg_we),
    .lo_i       (lo_w),
    .hi_i       (hi_w),
    .valid_i    (valid_w),
    .err_pri_o  (err_pri_ovl_o),
    .err_sec_o  (err_sec_ovl_o),
    .err_top_o  (err_top_ovl_o),
    .err_size_o (err_size_o)
  );

  assign batt_on_o = vcc_below_bat && stby_en;

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot({pri_sel_o, sec_sel_o, sram_sel_o, io_sel_o, pio_sel_o, none_sel_o}));

  // R3
  pri_yield_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|pri_sel_o) |-> (hit_w[N_WIN-1:SEC0] == '0));

  // R2
  none_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    none_sel_o |-> (hit_w == '0));

  // R12
  batt_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    batt_on_o |-> vcc_below_bat);

endmodule

// File: tb/sim_memsel_resolver.sv
module sim_memsel_resolver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] addr = '0;
  logic        vcc_below_bat = 1'b0;
  logic        stby_en = 1'b0;
  logic [3:0]  pri_sel;
  logic [1:0]  sec_sel;
  logic        sram_sel, io_sel, pio_sel, none_sel;
  logic        e_pri, e_sec, e_top, e_size, batt_on;

  int n_chk = 0;
  int n_fail = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  logic [15:0] mlo [10];
  logic [15:0] mhi [10];
  bit          men [10];
  logic [3:0]  merr;

  always #5 clk = ~clk;

  memsel_resolver u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .addr(addr), .vcc_below_bat(vcc_below_bat),
    .stby_en(stby_en), .pri_sel_o(pri_sel), .sec_sel_o(sec_sel),
    .sram_sel_o(sram_sel), .io_sel_o(io_sel), .pio_sel_o(pio_sel),
    .none_sel_o(none_sel), .err_pri_ovl_o(e_pri), .err_sec_ovl_o(e_sec),
    .err_top_ovl_o(e_top), .err_size_o(e_size), .batt_on_o(batt_on)
  );

  function automatic bit mhit(int i, logic [15:0] a);
    return men[i] && (mlo[i] <= mhi[i]) && (a >= mlo[i]) && (a <= mhi[i]);
  endfunction

  function automatic logic [9:0] exp_sel(logic [15:0] a);
    logic [3:0] p;
    logic [1:0] s;
    bit sr, io, pio, got;
    p = '0; s = '0; io = 0; pio = 0; got = 0;
    sr = mhit(6, a) || mhit(7, a);
    if (sr) got = 1;
    else if (mhit(8, a)) begin io = 1; got = 1; end
    else if (mhit(9, a)) begin pio = 1; got = 1; end
    for (int k = 4; k < 6; k++) if (!got && mhit(k, a)) begin s[k-4] = 1'b1; got = 1; end
    for (int k = 0; k < 4; k++) if (!got && mhit(k, a)) begin p[k] = 1'b1; got = 1; end
    return {p, s, sr, io, pio, !got};
  endfunction

  function automatic bit mmeet(int i, int j);
    return men[i] && men[j] && mlo[i] <= mhi[i] && mlo[j] <= mhi[j] &&
           mlo[i] <= mhi[j] && mlo[j] <= mhi[i];
  endfunction

  function automatic int grp(int i);
    return (i < 8) ? 0 : i - 7;
  endfunction

  function automatic logic [3:0] exp_err();
    bit p, s, t, z;
    int span;
    p = 0; s = 0; t = 0; z = 0;
    for (int i = 0; i < 10; i++) begin
      for (int j = i + 1; j < 10; j++) begin
        if (mmeet(i, j)) begin
          if (j < 4) p = 1;
          else if (i >= 4 && j < 6) s = 1;
          else if (i >= 6 && grp(i) != grp(j)) t = 1;
        end
      end
      if (i < 6 && men[i] && mlo[i] <= mhi[i]) begin
        span = int'(mhi[i]) - int'(mlo[i]) + 1;
        if (span > ((i < 4) ? 16384 : 8192)) z = 1;
      end
    end
    return {p, s, t, z};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 10; i++) begin mlo[i] <= '0; mhi[i] <= '0; men[i] <= 0; end
      merr <= '0;
    end else begin
      merr <= exp_err();
      if (cfg_we && cfg_addr[5:2] < 4'd10) begin
        case (cfg_addr[1:0])
          2'd0: mlo[cfg_addr[5:2]] <= cfg_wdata;
          2'd1: mhi[cfg_addr[5:2]] <= cfg_wdata;
          2'd2: men[cfg_addr[5:2]] <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (live) begin
      chk("R3/R4 selects", {6'd0, pri_sel, sec_sel, sram_sel, io_sel, pio_sel, none_sel},
          {6'd0, exp_sel(addr)});
      chk("R11 error flags", {12'd0, e_pri, e_sec, e_top, e_size}, {12'd0, merr});
      chk("R12 battery", {15'd0, batt_on}, {15'd0, vcc_below_bat & stby_en});
    end
  end

  task automatic wr(int idx, int fld, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {4'(idx), 2'(fld)}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic win(int idx, logic [15:0] lo, logic [15:0] hi);
    wr(idx, 0, lo); wr(idx, 1, hi); wr(idx, 2, 16'd1);
  endtask

  task automatic probe(logic [15:0] a, logic [9:0] exp, string tag);
    @(negedge clk);
    addr = a;
    #2;
    chk(tag, {6'd0, pri_sel, sec_sel, sram_sel, io_sel, pio_sel, none_sel}, {6'd0, exp});
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #2;
  endtask

  task automatic edges(int idx);
    probe(mlo[idx] - 16'd1, exp_sel(mlo[idx] - 16'd1), "R2 below lower bound");
    probe(mlo[idx], exp_sel(mlo[idx]), "R2 at lower bound");
    probe(mhi[idx], exp_sel(mhi[idx]), "R2 at upper bound");
    probe(mhi[idx] + 16'd1, exp_sel(mhi[idx] + 16'd1), "R2 above upper bound");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk("R1 reset none_sel", {15'd0, none_sel}, 16'd1);
    chk("R1 reset errors", {12'd0, e_pri, e_sec, e_top, e_size}, 16'd0);
    live = 1'b1;

    // R6 example mapping
    win(0, 16'h8000, 16'hBFFF);
    win(4, 16'h8000, 16'h9FFF);
    win(6, 16'h8000, 16'h87FF);
    probe(16'h7FFF, 10'b0000_00_0001, "R6 7FFF none");
    probe(16'h8000, 10'b0000_00_1000, "R6 8000 SRAM");
    probe(16'h87FF, 10'b0000_00_1000, "R6 87FF SRAM");
    probe(16'h8800, 10'b0000_01_0000, "R6 8800 secondary 0");
    probe(16'h9FFF, 10'b0000_01_0000, "R6 9FFF secondary 0");
    probe(16'hA000, 10'b0001_00_0000, "R6 A000 primary 0");
    probe(16'hBFFF, 10'b0001_00_0000, "R6 BFFF primary 0");
    probe(16'hC000, 10'b0000_00_0001, "R6 C000 none");
    settle();
    chk("R7 no error in legal example", {12'd0, e_pri, e_sec, e_top, e_size}, 16'd0);
    for (int i = 0; i < 10; i++) if (men[i]) edges(i);

    // R5 second SRAM term
    win(7, 16'hC000, 16'hC0FF);
    probe(16'hC080, 10'b0000_00_1000, "R5 SRAM term 1");
    // R9 I/O and peripheral
    win(8, 16'hD000, 16'hD0FF);
    win(9, 16'hE000, 16'hE0FF);
    probe(16'hD000, 10'b0000_00_0100, "R9 I/O select");
    probe(16'hE0FF, 10'b0000_00_0010, "R9 peripheral select");
    edges(8); edges(9);

    // R1 ignored field and index
    wr(8, 3, 16'h0000);
    wr(12, 0, 16'h0000);
    wr(12, 2, 16'h0000);
    probe(16'hD000, 10'b0000_00_0100, "R1 ignored writes leave I/O window");

    // R9 SRAM terms overlapping each other is legal
    win(7, 16'h8100, 16'h8200);
    settle();
    chk("R9 SRAM terms overlap not error", {15'd0, e_top}, 16'd0);
    win(8, 16'h8000, 16'h8000);
    settle();
    chk("R9 SRAM vs I/O overlap", {15'd0, e_top}, 16'd1);
    probe(16'h8000, 10'b0000_00_1000, "R4 SRAM wins over I/O");
    wr(8, 2, 16'd0);
    settle();
    chk("R11 error clears after fix", {15'd0, e_top}, 16'd0);

    // R7 primary overlap
    win(1, 16'hB000, 16'hB0FF);
    settle();
    chk("R7 primary overlap", {15'd0, e_pri}, 16'd1);
    probe(16'hB000, 10'b0001_00_0000, "R4 lowest primary index wins");
    wr(1, 2, 16'd0);

    // R8 secondary overlap
    win(5, 16'h9000, 16'h90FF);
    settle();
    chk("R8 secondary overlap", {15'd0, e_sec}, 16'd1);
    wr(5, 2, 16'd0);

    // R10 size boundary
    win(2, 16'h0000, 16'h3FFF);
    settle();
    chk("R10 primary at sector size", {15'd0, e_size}, 16'd0);
    wr(2, 1, 16'h4000);
    settle();
    chk("R10 primary over sector size", {15'd0, e_size}, 16'd1);
    wr(2, 1, 16'h3FFF);
    win(5, 16'h4000, 16'h6000);
    settle();
    chk("R10 secondary over sector size", {15'd0, e_size}, 16'd1);

    // R12 battery
    @(negedge clk); vcc_below_bat = 1'b1; stby_en = 1'b1; #2;
    chk("R12 battery on", {15'd0, batt_on}, 16'd1);
    @(negedge clk); stby_en = 1'b0; #2;
    chk("R12 battery off without standby", {15'd0, batt_on}, 16'd0);

    // random configurations and addresses
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 3) == 0)
        wr($urandom_range(0, 9), $urandom_range(0, 2), 16'($urandom));
      @(negedge clk);
      addr = ($urandom_range(0, 1) == 0) ? 16'($urandom) : mlo[$urandom_range(0, 9)];
      vcc_below_bat = 1'($urandom); stby_en = 1'($urandom);
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule